// File: doc/BRIEF.md
# DRAM Compressed Parallel Test Mode Controller

This block sits on the device side of an asynchronous DRAM interface. It samples the four active-low strobe levels (row strobe, column strobe, write enable, output enable) with a fast clock, finds their edges, and decodes the strobe sequence of each cycle. A column-before-row cycle with write enable held low and a key pattern on the row address puts the device into a parallel test mode. Any other refresh-only sequence takes it out again.

In normal mode a row/column access reads or writes one nibble in a small internal array. The two lowest column bits pick one of four sub-blocks. In test mode those two bits are ignored. A write stores the nibble into all four sub-blocks of the addressed group at once. A read returns, for each data pin, a 1 when the four stored bits of that pin agree and a 0 when they do not. The array is kept small through parameters so that a bench can sweep all of it.

Top module: `tm_dram_core`

## Requirements
- R1: After reset, test_mode_o is 0 and rdata_o is 0.
- R2: In normal mode, an access latches the row from addr_i[ROW_BITS-1:0] at the row strobe fall and the column from addr_i[COL_BITS-1:0] at the column strobe fall. Column bits [1:0] select the sub-block. A write stores wdata_i and a read returns the stored nibble.
- R3: Test mode is entered when, at the sample where ras_n_i first reads low, cas_n_i and we_n_i are low both at that sample and at the sample before, and addr_i[KEY_W-1:0] is all ones. Address bits above KEY_W have no effect.
- R4: A column-before-row cycle with we_n_i high, or with any zero in addr_i[KEY_W-1:0], does not enter test mode.
- R5: In test mode, a write stores wdata_i into all four sub-blocks of the addressed row and upper column bits, whatever column bits [1:0] are.
- R6: In test mode, a read sets rdata_o bit i to 1 exactly when bit i of the four sub-blocks in the addressed group are equal.
- R7: In test mode, a further keyed entry cycle keeps test mode set.
- R8: A column-before-row cycle that is not a keyed entry clears test mode. This includes the hidden form, where the column strobe stays low from a preceding read.
- R9: A row strobe low period with no column strobe fall, started with the column strobe high, clears test mode when the row strobe rises.
- R10: Reads and writes leave the mode unchanged.
- R11: rdata_o is 0 while the sampled oe_n_i is high. Several column strobe falls within one row strobe low period each perform an access (page mode).
- R12: If we_n_i is low only at the sample of the row strobe fall and high at the sample before, test mode is not entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ras_n_i | input | 1 | Row strobe level, active low |
| cas_n_i | input | 1 | Column strobe level, active low |
| we_n_i | input | 1 | Write enable level, active low |
| oe_n_i | input | 1 | Output enable level, active low |
| addr_i | input | ADDR_W | Multiplexed row/column address |
| wdata_i | input | DQ_W | Write data |
| rdata_o | output | DQ_W | Read data or per-pin compare result |
| test_mode_o | output | 1 | Test mode flag |

## Verification
The assertions assume the strobe levels are already synchronous to clk_i. They also assume each level is held for at least two samples, so that every edge is seen once as a fall or a rise, and that the address and write data are stable around each strobe edge. The bench drives every input on the falling clock edge and holds each step for three cycles. Each cycle follows the strobe ordering of a real access, refresh or entry, so the decoder never sees a row and column edge in the same sample.

// File: rtl/tm_dram_pkg.sv
package tm_dram_pkg;
  typedef struct packed {
    logic ras_n;
    logic cas_n;
    logic we_n;
    logic oe_n;
  } strobe_t;

  localparam strobe_t STROBE_IDLE = '{ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1, oe_n: 1'b1};

  typedef enum logic {MODE_NORMAL = 1'b0, MODE_TEST = 1'b1} mode_e;
endpackage

// File: rtl/tm_strobe_dec.sv
module tm_strobe_dec
  import tm_dram_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DQ_W   = 4,
  parameter int KEY_W  = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  strobe_t           strobe_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DQ_W-1:0]   wdata_i,
  output strobe_t           strobe_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DQ_W-1:0]   wdata_o,
  output logic              ras_fall_o,
  output logic              ras_rise_o,
  output logic              cas_fall_o,
  output logic              key_cbr_o,
  output logic              plain_cbr_o
);
  strobe_t s1_q, s2_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DQ_W-1:0]   wdata_q;
  logic              cbr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q    <= STROBE_IDLE;
      s2_q    <= STROBE_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      s1_q    <= strobe_i;
      s2_q    <= s1_q;
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
    end
  end

  assign ras_fall_o = s2_q.ras_n & ~s1_q.ras_n;
  assign ras_rise_o = ~s2_q.ras_n & s1_q.ras_n;
  assign cas_fall_o = s2_q.cas_n & ~s1_q.cas_n;
  assign cbr        = ras_fall_o & ~s1_q.cas_n;
  // entry needs WE and CAS low one sample ahead of the RAS fall (setup)
  assign key_cbr_o  = cbr & ~s2_q.cas_n & ~s1_q.we_n & ~s2_q.we_n & (&addr_q[KEY_W-1:0]);
  assign plain_cbr_o = cbr & ~key_cbr_o;

  assign strobe_o = s1_q;
  assign addr_o   = addr_q;
  assign wdata_o  = wdata_q;
endmodule

// File: rtl/tm_mode_ctrl.sv
module tm_mode_ctrl
  import tm_dram_pkg::*;
#(
  parameter int ROW_BITS = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  strobe_t             strobe_i,
  input  logic [ROW_BITS-1:0] row_addr_i,
  input  logic                ras_fall_i,
  input  logic                ras_rise_i,
  input  logic                cas_fall_i,
  input  logic                key_cbr_i,
  input  logic                plain_cbr_i,
  output logic [ROW_BITS-1:0] row_o,
  output logic                rd_evt_o,
  output logic                wr_evt_o,
  output logic                test_mode_o
);
  mode_e mode_q;
  logic  row_open_q, col_seen_q, access;
  logic [ROW_BITS-1:0] row_q;

  assign access   = cas_fall_i & row_open_q & ~strobe_i.ras_n;
  assign rd_evt_o = access & strobe_i.we_n;
  assign wr_evt_o = access & ~strobe_i.we_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q     <= MODE_NORMAL;
      row_open_q <= 1'b0;
      col_seen_q <= 1'b0;
      row_q      <= '0;
    end else begin
      if (ras_fall_i && !(key_cbr_i || plain_cbr_i)) begin
        row_open_q <= 1'b1;
        col_seen_q <= 1'b0;
        row_q      <= row_addr_i;
      end else if (ras_rise_i) begin
        row_open_q <= 1'b0;
        col_seen_q <= 1'b0;
      end else if (access) begin
        col_seen_q <= 1'b1;
      end

      if (key_cbr_i)
        mode_q <= MODE_TEST;
      else if (plain_cbr_i)
        mode_q <= MODE_NORMAL;
      else if (ras_rise_i && row_open_q && !col_seen_q)
        mode_q <= MODE_NORMAL;  // RAS-only refresh
    end
  end

  assign row_o       = row_q;
  assign test_mode_o = (mode_q == MODE_TEST);
endmodule

// File: rtl/tm_array.sv
module tm_array #(
  parameter int ROW_BITS = 2,
  parameter int COL_BITS = 3,
  parameter int DQ_W     = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_i,
  input  logic                rd_i,
  input  logic                test_i,
  input  logic [ROW_BITS-1:0] row_i,
  input  logic [COL_BITS-1:0] col_i,
  input  logic [DQ_W-1:0]     wdata_i,
  output logic [DQ_W-1:0]     dout_o
);
  localparam int IDX_W = ROW_BITS + COL_BITS;
  localparam int DEPTH = 1 << IDX_W;
  localparam int SUBS  = 4;

  logic [DQ_W-1:0] mem [DEPTH];
  logic [IDX_W-1:0] idx;
  logic [DQ_W-1:0] sub_q [SUBS];
  logic [DQ_W-1:0] cmp;

  assign idx = {row_i, col_i};

  always_ff @(posedge clk_i) begin
    if (wr_i) begin
      if (test_i) begin
        for (int s = 0; s < SUBS; s++)
          mem[{idx[IDX_W-1:2], 2'(s)}] <= wdata_i;
      end else begin
        mem[idx] <= wdata_i;
      end
    end
  end

  for (genvar s = 0; s < SUBS; s++) begin : g_sub
    assign sub_q[s] = mem[{idx[IDX_W-1:2], 2'(s)}];
  end

  for (genvar b = 0; b < DQ_W; b++) begin : g_cmp
    assign cmp[b] = (sub_q[0][b] == sub_q[1][b]) &&
                    (sub_q[0][b] == sub_q[2][b]) &&
                    (sub_q[0][b] == sub_q[3][b]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      dout_o <= '0;
    else if (rd_i)
      dout_o <= test_i ? cmp : mem[idx];
  end
endmodule

// File: rtl/tm_dram_core.sv
module tm_dram_core
  import tm_dram_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int DQ_W     = 4,
  parameter int KEY_W    = 10,
  parameter int ROW_BITS = 2,
  parameter int COL_BITS = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ras_n_i,
  input  logic              cas_n_i,
  input  logic              we_n_i,
  input  logic              oe_n_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DQ_W-1:0]   wdata_i,
  output logic [DQ_W-1:0]   rdata_o,
  output logic              test_mode_o
);
  strobe_t strobe_in, strobe_s;
  logic [ADDR_W-1:0] addr_s;
  logic [DQ_W-1:0]   wdata_s, dout;
  logic [ROW_BITS-1:0] row;
  logic ras_fall, ras_rise, cas_fall, key_cbr, plain_cbr;
  logic rd_evt, wr_evt, oe_n_s;

  assign strobe_in = '{ras_n: ras_n_i, cas_n: cas_n_i, we_n: we_n_i, oe_n: oe_n_i};

  tm_strobe_dec #(.ADDR_W(ADDR_W), .DQ_W(DQ_W), .KEY_W(KEY_W)) u_dec (
    .clk_i, .rst_ni,
    .strobe_i   (strobe_in),
    .addr_i, .wdata_i,
    .strobe_o   (strobe_s),
    .addr_o     (addr_s),
    .wdata_o    (wdata_s),
    .ras_fall_o (ras_fall),
    .ras_rise_o (ras_rise),
    .cas_fall_o (cas_fall),
    .key_cbr_o  (key_cbr),
    .plain_cbr_o(plain_cbr)
  );

  tm_mode_ctrl #(.ROW_BITS(ROW_BITS)) u_mode (
    .clk_i, .rst_ni,
    .strobe_i   (strobe_s),
    .row_addr_i (addr_s[ROW_BITS-1:0]),
    .ras_fall_i (ras_fall),
    .ras_rise_i (ras_rise),
    .cas_fall_i (cas_fall),
    .key_cbr_i  (key_cbr),
    .plain_cbr_i(plain_cbr),
    .row_o      (row),
    .rd_evt_o   (rd_evt),
    .wr_evt_o   (wr_evt),
    .test_mode_o
  );

  tm_array #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS), .DQ_W(DQ_W)) u_array (
    .clk_i, .rst_ni,
    .wr_i    (wr_evt),
    .rd_i    (rd_evt),
    .test_i  (test_mode_o),
    .row_i   (row),
    .col_i   (addr_s[COL_BITS-1:0]),
    .wdata_i (wdata_s),
    .dout_o  (dout)
  );

  assign oe_n_s  = strobe_s.oe_n;
  assign rdata_o = oe_n_s ? '0 : dout;
endmodule

// File: rtl/tm_dram_core_chk.sv
module tm_dram_core_chk #(
  parameter int DQ_W = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            test_mode_o,
  input logic [DQ_W-1:0] rdata_o,
  input logic            key_cbr,
  input logic            plain_cbr,
  input logic            ras_fall,
  input logic            ras_rise,
  input logic            rd_evt,
  input logic            wr_evt,
  input logic            oe_n_s
);
  AST_ENTER_ON_KEY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_cbr |=> test_mode_o);  // R3
  AST_NO_ENTRY_WITHOUT_KEY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(test_mode_o) |-> $past(key_cbr));  // R4
  AST_CBR_EXITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    plain_cbr |=> !test_mode_o);  // R8
  AST_MODE_ON_RAS_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(test_mode_o) |-> $past(ras_fall || ras_rise));  // R9
  AST_ACCESS_KEEPS_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_evt || wr_evt) |=> $stable(test_mode_o));  // R10
  AST_RDATA_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rdata_o) |-> ($past(rd_evt) || !$stable(oe_n_s)));  // R11
endmodule

bind tm_dram_core tm_dram_core_chk #(.DQ_W(DQ_W)) u_chk (
  .clk_i, .rst_ni, .test_mode_o, .rdata_o, .key_cbr, .plain_cbr,
  .ras_fall, .ras_rise, .rd_evt, .wr_evt, .oe_n_s
);

// File: tb/tb_tm_dram_core.sv
module tb_tm_dram_core;
  localparam int ADDR_W = 12, DQ_W = 4, KEY_W = 10, ROW_BITS = 2, COL_BITS = 3;
  localparam int NROW = 1 << ROW_BITS, NCOL = 1 << COL_BITS, NGRP = NCOL / 4;
  localparam logic [ADDR_W-1:0] KEY = ADDR_W'((1 << KEY_W) - 1);

  logic clk = 1'b0, rst_ni = 1'b0;
  logic ras_n = 1, cas_n = 1, we_n = 1, oe_n = 1;
  logic [ADDR_W-1:0] addr = '0;
  logic [DQ_W-1:0] wdata = '0;
  logic [DQ_W-1:0] rdata;
  logic test_mode;
  int checks = 0, errors = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  tm_dram_core dut (
    .clk_i(clk), .rst_ni(rst_ni), .ras_n_i(ras_n), .cas_n_i(cas_n), .we_n_i(we_n),
    .oe_n_i(oe_n), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .test_mode_o(test_mode)
  );

  task automatic step();
    repeat (3) @(negedge clk);
  endtask

  task automatic check(string req, logic [DQ_W-1:0] act, logic [DQ_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [DQ_W-1:0] pat_f(int idx);
    return DQ_W'((idx * 7 + 3) % 16);
  endfunction

  function automatic logic [DQ_W-1:0] pat_g(int r, int g);
    return DQ_W'((r * 5 + g * 3 + 1) % 16);
  endfunction

  task automatic wr(int row, int col, logic [DQ_W-1:0] d);
    addr = ADDR_W'(row); step();
    ras_n = 0; step();
    addr = ADDR_W'(col); we_n = 0; wdata = d; step();
    cas_n = 0; step();
    cas_n = 1; we_n = 1; step();
    ras_n = 1; step();
  endtask

  task automatic rd(int row, int col, output logic [DQ_W-1:0] d);
    addr = ADDR_W'(row); step();
    ras_n = 0; step();
    addr = ADDR_W'(col); oe_n = 0; step();
    cas_n = 0; step();
    d = rdata;
    cas_n = 1; step();
    ras_n = 1; oe_n = 1; step();
  endtask

  task automatic cbr(logic [ADDR_W-1:0] a, logic we_low);
    addr = a; cas_n = 0; we_n = ~we_low; step();
    ras_n = 0; step();
    ras_n = 1; step();
    cas_n = 1; we_n = 1; step();
  endtask

  initial begin
    #1ms;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [DQ_W-1:0] d, e;
    step();
    check("R1 mode", DQ_W'(test_mode), '0);
    check("R1 rdata", rdata, '0);
    rst_ni = 1; step();

    // R2: exhaustive normal write/read
    for (int r = 0; r < NROW; r++)
      for (int c = 0; c < NCOL; c++) wr(r, c, pat_f(r * NCOL + c));
    for (int r = 0; r < NROW; r++)
      for (int c = 0; c < NCOL; c++) begin
        rd(r, c, d); check("R2", d, pat_f(r * NCOL + c));
      end

    // R3: entry, upper address bits don't care
    cbr(KEY, 1'b1);
    check("R3 entry", DQ_W'(test_mode), 1);

    // R6: compare of differing data, R10: reads keep mode
    for (int r = 0; r < NROW; r++)
      for (int g = 0; g < NGRP; g++) begin
        e = '0;
        for (int b = 0; b < DQ_W; b++) begin
          logic v0;
          logic same;
          v0 = pat_f(r * NCOL + g * 4)[b];
          same = 1'b1;
          for (int s = 1; s < 4; s++) if (pat_f(r * NCOL + g * 4 + s)[b] != v0) same = 1'b0;
          e[b] = same;
        end
        rd(r, g * 4 + ((r + g) % 4), d); check("R6 differ", d, e);
      end
    check("R10 mode kept", DQ_W'(test_mode), 1);

    // R5: test write to all sub-blocks
    for (int r = 0; r < NROW; r++)
      for (int g = 0; g < NGRP; g++) wr(r, g * 4 + ((r * 3 + g) % 4), pat_g(r, g));
    for (int r = 0; r < NROW; r++)
      for (int g = 0; g < NGRP; g++) begin
        rd(r, g * 4 + 1, d); check("R6 equal", d, '1);
      end

    // R7: further keyed entry keeps mode
    cbr(KEY | ADDR_W'(1 << KEY_W), 1'b1);
    check("R7 stay", DQ_W'(test_mode), 1);

    // R8: plain CBR exits
    cbr(KEY, 1'b0);
    check("R8 cbr exit", DQ_W'(test_mode), 0);

    for (int r = 0; r < NROW; r++)
      for (int c = 0; c < NCOL; c++) begin
        rd(r, c, d); check("R5", d, pat_g(r, c / 4));
      end

    // R4: no entry without WE low or with key mismatch
    cbr(KEY & ~ADDR_W'(2), 1'b1);
    check("R4 key miss", DQ_W'(test_mode), 0);
    cbr(KEY, 1'b0);
    check("R4 we high", DQ_W'(test_mode), 0);

    // R12: WE low only at the fall sample
    addr = KEY; cas_n = 0; step();
    we_n = 0; ras_n = 0; step();
    ras_n = 1; step();
    cas_n = 1; we_n = 1; step();
    check("R12 setup", DQ_W'(test_mode), 0);

    // R9: RAS-only refresh exits
    cbr(KEY, 1'b1);
    check("R3 re-entry", DQ_W'(test_mode), 1);
    addr = 2; step(); ras_n = 0; step(); ras_n = 1; step();
    check("R9 ras-only exit", DQ_W'(test_mode), 0);

    // R8 hidden refresh: CAS stays low from a read
    cbr(KEY, 1'b1);
    addr = 1; step(); ras_n = 0; step();
    addr = 2; oe_n = 0; step(); cas_n = 0; step();
    check("R10 read in test", DQ_W'(test_mode), 1);
    ras_n = 1; step(); ras_n = 0; step(); ras_n = 1; step();
    cas_n = 1; oe_n = 1; step();
    check("R8 hidden exit", DQ_W'(test_mode), 0);

    // R11: OE high forces zero; page mode
    wr(3, 5, 4'hA);
    addr = 3; step(); ras_n = 0; step();
    addr = 5; step(); cas_n = 0; step();
    check("R11 oe high", rdata, '0);
    oe_n = 0; step();
    check("R11 oe low", rdata, 4'hA);
    cas_n = 1; addr = 0; step(); cas_n = 0; step();
    check("R11 page", rdata, pat_g(3, 0));
    cas_n = 1; step(); ras_n = 1; oe_n = 1; step();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule